// File: doc/BRIEF.md
# Single-Precision Round-and-Pack Unit

This block finishes a single-precision arithmetic result. It takes a sign, an unbiased signed exponent and a 27-bit extended significand, and returns the packed 32-bit word with inexact, underflow and overflow flags. The significand holds the hidden bit, 23 fraction bits and three extra low bits (guard, round, sticky). The block rounds in one of four modes and denormalizes results too small to be normal. It renormalizes when rounding carries out, and it saturates or produces infinity on overflow. An optional flush-to-zero control replaces tiny results with a mode-dependent signed zero or smallest normal.

The unit is one register stage deep. Inputs presented before a rising clock edge appear on the outputs after that edge. Callers must present a normalized significand (bit 26 set). NaN, infinity and exact zero are handled upstream and are not accepted here.

Top module: `sp_round_pack`

## Requirements
- R1: Outputs are registered. Each output reflects the inputs sampled at the previous rising edge, and an active-low reset clears the result and all flags to zero. An exact normal input (low three significand bits zero, exponent from -126 to 127) packs as sign in bit 31, exponent+127 in bits 30:23 and significand bits 25:3 in bits 22:0, with all flags clear.
- R2: Mode 00 rounds to nearest, with ties going to the even value.
- R3: Mode 01 truncates toward zero and never produces an infinity.
- R4: Mode 10 adds one unit in the last place when the result is inexact and positive. Mode 11 does the same when it is inexact and negative.
- R5: Inexact is raised whenever any bit is lost, including bits shifted out during denormalization.
- R6: If rounding carries out of the 24-bit significand, the significand is halved and the exponent goes up by one.
- R7: If the exponent after rounding exceeds 127, overflow and inexact are raised. The result is then signed infinity (0x7F800000 pattern) or the signed largest finite value (exponent field 0xFE, all fraction ones), according to mode and sign: 00 gives infinity; 01 gives the largest value; 10 gives infinity if positive, else the largest value; 11 gives infinity if negative, else the largest value. An input exponent of 126 or below never overflows.
- R8: Without flush-to-zero, an exponent below -126 is shifted right by the deficit. Lost bits are ORed into the sticky bit. The result is then rounded and packed with exponent field 0, and underflow is raised only when the result is inexact.
- R9: At exponent -127, if rounding the unshifted significand would carry out, the result is the smallest normal (exponent field 1, zero fraction) with inexact raised and underflow clear.
- R10: With flush-to-zero set and exponent below -126, underflow and inexact are raised and overflow is clear. Modes 00 and 01 give signed zero. Mode 10 gives the smallest positive normal for positive values and negative zero otherwise. Mode 11 gives positive zero for positive values and the smallest negative normal otherwise.
- R11: A denormalized value that rounds up to the hidden position is packed as a normal with exponent field 1, and it still raises underflow and inexact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sign_i | input | 1 | Sign of the value |
| exp_i | input | 10 | Unbiased exponent, two's complement |
| sig_i | input | 27 | Hidden bit, 23 fraction bits, guard, round, sticky |
| rmode_i | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| ftz_i | input | 1 | Flush tiny results |
| result_o | output | 32 | Packed single-precision word |
| inexact_o | output | 1 | Result differs from the exact value |
| underflow_o | output | 1 | Tiny and inexact, or flushed |
| overflow_o | output | 1 | Exponent above range after rounding |

## Verification
The bench concentrates on the exponents around -127 and -126. A design that tested tininess before rounding would flag underflow there, or would return a subnormal where the smallest normal is due. Overflow vectors at exponent 127 with carry-out, and at higher exponents, cover all four modes and both signs. A swapped saturation table shows up as infinity where the largest finite value is expected. Deep underflow and sticky-only patterns catch a shifter that drops shifted-out bits, which would leave inexact clear and break rounding in the directed modes. Ties with even and odd last bits expose a rounder that always rounds half up.

// File: rtl/sp_round_pack.sv
module sp_round_pack #(
  parameter int EXP_W = 10,
  parameter int SIG_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [1:0]       rmode_i,
  input  logic             ftz_i,
  output logic [31:0]      result_o,
  output logic             inexact_o,
  output logic             underflow_o,
  output logic             overflow_o
);
  localparam int EW = EXP_W + 1;
  localparam logic signed [EW-1:0] EMIN = -EW'(126);
  localparam logic signed [EW-1:0] EMAX = EW'(127);
  localparam logic signed [EW-1:0] SHMAX = EW'(SIG_W + 1);

  function automatic logic [SIG_W:0] rnd(input logic [SIG_W-1:0] m, input logic s,
                                         input logic [1:0] md);
    logic [SIG_W:0] x;
    x = {1'b0, m};
    if (m[2:0] != 3'd0) begin
      case (md)
        2'b00: x = x + (SIG_W+1)'(3) + (SIG_W+1)'(m[3]);
        2'b01: x = x;
        2'b10: x = s ? x : x + (SIG_W+1)'(8);
        default: x = s ? x + (SIG_W+1)'(8) : x;
      endcase
    end
    return x;
  endfunction

  logic signed [EW-1:0] e0, es, e1, e2;
  logic [4:0]           sh;
  logic [SIG_W-1:0]     den, m1, m2;
  logic [SIG_W:0]       r0, r2;
  logic                 tiny, notiny, lost, ix, uf, ovf;
  logic [31:0]          res, sat_res, ftz_res;

  assign e0     = EW'(signed'(exp_i));
  assign es     = EMIN - e0;
  assign tiny   = e0 < EMIN;
  assign sh     = (es > SHMAX) ? 5'(SHMAX) : es[4:0];
  assign den    = sig_i >> sh;
  assign lost   = (den << sh) != sig_i;
  assign r0     = rnd(sig_i, sign_i, rmode_i);
  assign notiny = (e0 == EMIN - EW'(1)) && r0[SIG_W];

  always_comb begin
    if (notiny)    m1 = r0[SIG_W:1] & ~SIG_W'(7);
    else if (tiny) m1 = den | SIG_W'(lost);
    else           m1 = sig_i;
    e1 = tiny ? EMIN : e0;
  end

  assign r2  = rnd(m1, sign_i, rmode_i);
  assign m2  = r2[SIG_W] ? r2[SIG_W:1] : r2[SIG_W-1:0];
  assign e2  = e1 + EW'(r2[SIG_W]);
  assign ovf = e2 > EMAX;
  assign ix  = notiny | (m1[2:0] != 3'd0);
  assign uf  = (m1[2:0] != 3'd0) & ~m1[SIG_W-1];

  always_comb begin
    case (rmode_i)
      2'b00:   sat_res = {sign_i, 8'hFF, 23'd0};
      2'b01:   sat_res = {sign_i, 8'hFE, {23{1'b1}}};
      2'b10:   sat_res = sign_i ? {1'b1, 8'hFE, {23{1'b1}}} : {1'b0, 8'hFF, 23'd0};
      default: sat_res = sign_i ? {1'b1, 8'hFF, 23'd0} : {1'b0, 8'hFE, {23{1'b1}}};
    endcase
    case (rmode_i)
      2'b10:   ftz_res = sign_i ? {1'b1, 31'd0} : {1'b0, 8'h01, 23'd0};
      2'b11:   ftz_res = sign_i ? {1'b1, 8'h01, 23'd0} : {1'b0, 31'd0};
      default: ftz_res = {sign_i, 31'd0};
    endcase
  end

  always_comb begin
    if (tiny && ftz_i)            res = ftz_res;
    else if (ovf)                 res = sat_res;
    else if (!m2[SIG_W-1])        res = {sign_i, 8'd0, m2[SIG_W-2:3]};
    else                          res = {sign_i, 8'(e2 + EW'(127)), m2[SIG_W-2:3]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o    <= '0;
      inexact_o   <= 1'b0;
      underflow_o <= 1'b0;
      overflow_o  <= 1'b0;
    end else if (tiny && ftz_i) begin
      result_o    <= res;
      inexact_o   <= 1'b1;
      underflow_o <= 1'b1;
      overflow_o  <= 1'b0;
    end else begin
      result_o    <= res;
      inexact_o   <= ix | ovf;
      underflow_o <= uf;
      overflow_o  <= ovf;
    end
  end
endmodule

module sp_round_pack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sign_i,
  input logic [9:0]  exp_i,
  input logic [26:0] sig_i,
  input logic [1:0]  rmode_i,
  input logic        ftz_i,
  input logic [31:0] result_o,
  input logic        inexact_o,
  input logic        underflow_o,
  input logic        overflow_o
);
  assert_ovf_inexact_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> inexact_o);
  assert_ovf_pattern_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> (result_o[30:23] == 8'hFF && result_o[22:0] == 23'd0) ||
                   (result_o[30:23] == 8'hFE && result_o[22:0] == {23{1'b1}}));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(exp_i) <= 126) |=> !overflow_o);
  assert_uf_inexact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> inexact_o);
  assert_ftz_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ftz_i && $signed(exp_i) < -126) |=> (underflow_o && inexact_o && !overflow_o));
  assert_rz_no_inf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rmode_i == 2'b01) |=> (result_o[30:23] != 8'hFF));
  assert_exact_pack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_i[26] && sig_i[2:0] == 3'd0 && $signed(exp_i) >= -126 && $signed(exp_i) <= 127)
    |=> (!inexact_o && !underflow_o && !overflow_o &&
         result_o == {$past(sign_i), 8'($past(exp_i) + 10'd127), $past(sig_i[25:3])}));
endmodule

bind sp_round_pack sp_round_pack_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .exp_i(exp_i), .sig_i(sig_i),
  .rmode_i(rmode_i), .ftz_i(ftz_i), .result_o(result_o), .inexact_o(inexact_o),
  .underflow_o(underflow_o), .overflow_o(overflow_o)
);

// File: tb/sp_round_pack_tb.sv
module sp_round_pack_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sign_i = 1'b0;
  logic [9:0]  exp_i = '0;
  logic [26:0] sig_i = 27'h4000000;
  logic [1:0]  rmode_i = '0;
  logic        ftz_i = 1'b0;
  logic [31:0] result_o;
  logic        inexact_o, underflow_o, overflow_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sp_round_pack dut_i (
    .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .exp_i(exp_i), .sig_i(sig_i),
    .rmode_i(rmode_i), .ftz_i(ftz_i), .result_o(result_o), .inexact_o(inexact_o),
    .underflow_o(underflow_o), .overflow_o(overflow_o)
  );

  // behavioural model: quantize to the grid of the final exponent
  function automatic logic [34:0] model(input bit s, input int e, input longint sg,
                                        input int md, input bit fz);
    longint keep, r, half;
    int eff, sh;
    bit ixx, up, gt, eq, ufl;
    logic [31:0] w;
    if (e < -126 && fz) begin
      if (md == 2 && !s)      w = 32'h00800000;
      else if (md == 3 && s)  w = 32'h80800000;
      else                    w = {s, 31'd0};
      return {w, 3'b110};
    end
    if (e == -127) begin
      keep = sg >> 3; r = sg & 7;
      gt = r > 4; eq = r == 4;
      case (md)
        0: up = gt || (eq && keep[0]);
        1: up = 0;
        2: up = (r != 0) && !s;
        default: up = (r != 0) && s;
      endcase
      if (keep + longint'(up) == (64'd1 << 24)) return {s, 8'h01, 23'd0, 3'b100};
    end
    eff = (e < -126) ? -126 : e;
    sh = 3 + eff - e;
    if (sh >= 40) begin
      keep = 0; ixx = 1; gt = 0; eq = 0;
    end else begin
      keep = sg >> sh;
      r = sg - (keep << sh);
      half = 64'd1 << (sh - 1);
      ixx = r != 0; gt = r > half; eq = r == half;
    end
    case (md)
      0: up = gt || (eq && keep[0]);
      1: up = 0;
      2: up = ixx && !s;
      default: up = ixx && s;
    endcase
    keep += longint'(up);
    if (keep == (64'd1 << 24)) begin keep = 64'd1 << 23; eff++; end
    ufl = ixx && (e < -126);
    if (eff > 127) begin
      if (md == 0 || (md == 2 && !s) || (md == 3 && s)) w = {s, 8'hFF, 23'd0};
      else w = {s, 8'hFE, 23'h7FFFFF};
      return {w, 3'b101};
    end
    if (keep < (64'd1 << 23)) w = {s, 8'd0, keep[22:0]};
    else w = {s, 8'(eff + 127), keep[22:0]};
    return {w, ixx, ufl, 1'b0};
  endfunction

  task automatic vec(input bit s, input int e, input logic [26:0] sg, input int md,
                     input bit fz, input string tag);
    logic [34:0] exp_v;
    @(negedge clk);
    sign_i = s; exp_i = 10'(e); sig_i = sg; rmode_i = 2'(md); ftz_i = fz;
    exp_v = model(s, e, longint'(sg), md, fz);
    @(posedge clk); #1;
    checks++;
    if ({result_o, inexact_o, underflow_o, overflow_o} !== exp_v) begin
      fails++;
      $display("FAIL %s: s=%0d e=%0d sig=%h md=%0d ftz=%0d got %h ix%0d uf%0d of%0d exp %h ix%0d uf%0d of%0d",
               tag, s, e, sg, md, fz, result_o, inexact_o, underflow_o, overflow_o,
               exp_v[34:3], exp_v[2], exp_v[1], exp_v[0]);
    end
  endtask

  function automatic string cls(input int e, input logic [26:0] sg, input int md, input bit fz);
    if (e < -126 && fz) return "R10";
    if (e > 126) return "R7";
    if (e < -126) return "R8";
    if (sg[2:0] == 0) return "R1";
    if (md == 0) return "R2";
    if (md == 1) return "R3";
    return "R4";
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({result_o, inexact_o, underflow_o, overflow_o} !== 35'd0) begin
      fails++;
      $display("FAIL R1 reset: got %h exp 0", {result_o, inexact_o, underflow_o, overflow_o});
    end
    rst_n = 1'b1;
    vec(0, 0, 27'h4000000, 0, 0, "R1 one");
    vec(1, 127, 27'h7FFFFF8, 1, 0, "R1 max exact");
    vec(0, -126, 27'h4000008, 0, 0, "R1 min normal");
    vec(0, 5, 27'h4000004, 0, 0, "R2 tie even");
    vec(0, 5, 27'h400000C, 0, 0, "R2 tie odd");
    vec(1, 5, 27'h4000005, 0, 0, "R2 above half");
    vec(0, 5, 27'h400000F, 1, 0, "R3 truncate");
    vec(0, 5, 27'h4000001, 2, 0, "R4 up pos");
    vec(1, 5, 27'h4000001, 2, 0, "R4 up neg");
    vec(1, 5, 27'h4000001, 3, 0, "R4 down neg");
    vec(0, 5, 27'h4000001, 3, 0, "R4 down pos");
    vec(0, 10, 27'h7FFFFFC, 0, 0, "R6 carry");
    vec(1, 10, 27'h7FFFFF9, 3, 0, "R6 carry down");
    for (int md = 0; md < 4; md++) begin
      vec(0, 127, 27'h7FFFFFC, md, 0, "R7 carry pos");
      vec(1, 127, 27'h7FFFFFC, md, 0, "R7 carry neg");
      vec(0, 200, 27'h4000000, md, 0, "R7 big pos");
      vec(1, 511, 27'h4000000, md, 0, "R7 big neg");
      vec(0, -127, 27'h7FFFFFF, md, 0, "R9 edge pos");
      vec(1, -127, 27'h7FFFFF9, md, 0, "R9 edge neg");
      vec(0, -127, 27'h7FFFFF8, md, 0, "R11 edge exact");
      vec(1, -130, 27'h4000001, md, 0, "R5 sticky only");
      vec(0, -150, 27'h4000000, md, 0, "R8 deep");
      vec(1, -512, 27'h7000000, md, 0, "R8 deepest");
      vec(0, -140, 27'h4000000, md, 1, "R10 ftz pos");
      vec(1, -140, 27'h4000000, md, 1, "R10 ftz neg");
      vec(0, -126, 27'h4000001, md, 1, "R10 ftz not tiny");
    end
    vec(0, -127, 27'h4000000, 0, 0, "R8 exact subnormal");
    vec(0, -149, 27'h4000000, 0, 0, "R8 smallest tie");
    vec(0, -128, 27'h7FFFFFE, 0, 0, "R11 round to normal");
    for (int i = 0; i < 6000; i++) begin
      bit s, fz;
      int e, md;
      logic [26:0] sg;
      s = 1'($urandom);
      md = int'($urandom % 4);
      fz = (($urandom % 4) == 0);
      case ($urandom % 4)
        0: e = -130 + int'($urandom % 10);
        1: e = 122 + int'($urandom % 10);
        2: e = -160 + int'($urandom % 40);
        default: e = -512 + int'($urandom % 1024);
      endcase
      sg = {1'b1, 26'($urandom)};
      if (($urandom % 3) == 0) sg[25:3] = 23'h7FFFFF;
      if (($urandom % 4) == 0) sg[2:0] = 3'd0;
      vec(s, e, sg, md, fz, cls(e, sg, md, fz));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule